// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Compressor

This block is a synthesizable, clock-sampled behavioural model of a 4-bit-wide multiplexed-address DRAM that includes the compressed parallel test mode. It is meant to sit inside a memory model used to verify a DRAM controller. The strobes `ras_n`, `cas_n` and `we_n` are sampled on every rising clock edge. The model tracks their edges to classify each row cycle as an access, a CAS-first refresh or a RAS-only refresh.

A row cycle in which both CAS and WE are low when RAS falls switches the model into test mode. In test mode the two lowest column bits are ignored. A write copies each data bit into four neighbouring columns of the same row. A read no longer returns stored data. Instead, each data pin reports whether its four cells agree: high for agreement, low for a mismatch.

A CAS-first refresh with WE high leaves test mode. So does a RAS-only refresh. Normal reads and repeated WE-and-CAS-first cycles keep the mode. Outside test mode the model is a plain memory that uses the full column address.

Top module: `dtm_compress_ram`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `test_mode` and `dq_oe` are both 0. A reset taken during test mode leaves it.
- R2: When RAS falls with `cas_n`=0 and `we_n`=0 sampled, `test_mode` is 1 from the next cycle on. Repeating that cycle keeps it at 1.
- R3: When RAS falls with `cas_n`=0 and `we_n`=1 sampled, `test_mode` is 0 from the next cycle on. This refresh cycle does not modify the array.
- R4: A RAS-low period that started with `cas_n`=1 and saw no CAS fall clears `test_mode` on the cycle after RAS rises. A period that did see a CAS fall, such as a normal read, keeps the mode.
- R5: Outside test mode, a CAS fall with `we_n`=0 in an access cycle writes `dq_in` to the cell at (row latched at the RAS fall, `addr` at the CAS fall). A CAS fall with `we_n`=1 puts that cell's data on `dq_out` with `dq_oe`=1 one cycle later.
- R6: In test mode, a write stores bit i of `dq_in` into bit i of the four cells whose column equals `addr` with bits 1:0 replaced by 00, 01, 10 and 11. Column bits 1:0 have no effect on which cells are written.
- R7: In test mode, a read drives `dq_out` bit i to 1 when bit i of those four cells is all 0 or all 1, and to 0 otherwise. Column bits 1:0 have no effect on the result.
- R8: `dq_out` and `dq_oe` keep their read value while CAS is high and RAS is low. `dq_oe` goes to 0 one cycle after both strobes are sampled high, or one cycle after a write CAS fall.
- R9: `test_mode` changes only in the cycle after a sampled RAS edge. Test-mode writes and reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data or per-pin pass/fail result |
| dq_oe | output | 1 | Output data valid / drive enable |
| test_mode | output | 1 | Compressed test mode is active |

## Verification
The assertions assume the strobes are synchronous to `clk` and that `ras_n` is held high through reset. With that assumption, the first sampled edge after reset is a real edge. They also assume that the CAS level at the sampled RAS fall alone decides the cycle type, so a CAS fall counts only inside an access cycle. The stimulus drives every input on the falling clock edge and keeps `ras_n` and `cas_n` high during reset. It holds WE for at least one full cycle on each side of the RAS fall in mode-change cycles, so every entry, refresh and access is unambiguous at the sampled edge.

// File: rtl/dtm_pkg.sv
// Package: shared types of the parallel test-mode DRAM model.
// Assumes nothing beyond IEEE 1800-2017.
package dtm_pkg;
    // Kind of the current row cycle, fixed at the sampled RAS fall.
    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ACCESS  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/dtm_strobe_dec.sv
// Strobe decoder: samples RAS/CAS/WE, classifies each row cycle and keeps
// the test-mode flag. Assumes strobes synchronous to clk, RAS high in reset.
module dtm_strobe_dec
    import dtm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_q,
    output logic              col_go,
    output logic              test_mode
);
    logic      ras_q;
    logic      cas_q;
    logic      cas_seen;
    cyc_kind_e kind_q;
    logic      ras_fall;
    logic      ras_rise;
    logic      cas_fall;

    // Edge detection against the previous sample.
    always_comb begin
        ras_fall = ras_q & ~ras_n;
        ras_rise = ~ras_q & ras_n;
        cas_fall = cas_q & ~cas_n;
        col_go   = (kind_q == CYC_ACCESS) & ~ras_n & ~ras_q & cas_fall;
    end

    // Cycle classification and test-mode tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q     <= 1'b1;
            cas_q     <= 1'b1;
            cas_seen  <= 1'b0;
            kind_q    <= CYC_IDLE;
            row_q     <= '0;
            test_mode <= 1'b0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (ras_fall) begin
                cas_seen <= 1'b0;
                if (!cas_n) begin
                    kind_q    <= CYC_REFRESH;
                    test_mode <= ~we_n;
                end else begin
                    kind_q <= CYC_ACCESS;
                    row_q  <= addr;
                end
            end else if (ras_rise) begin
                if (kind_q == CYC_ACCESS && !cas_seen) begin
                    test_mode <= 1'b0;
                end
                kind_q <= CYC_IDLE;
            end else if (col_go) begin
                cas_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtm_cell_array.sv
// Cell array: row-by-column storage with a normal port and a test-mode
// port that writes or compares a group of 2**GRP_BITS columns at once.
// Assumes wr_en only in an access cycle; contents are not reset.
module dtm_cell_array #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 4,
    parameter int GRP_BITS = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              tmode,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_norm,
    output logic [DATA_W-1:0] rdata_cmp
);
    localparam int IDX_W = 2 * ADDR_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam int GRP   = 1 << GRP_BITS;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx_full;
    logic [IDX_W-1:0]  idx_base;
    logic [GRP-1:0]    grp_bits [DATA_W];

    // Cell index of the addressed word and of its group's first word.
    always_comb begin
        idx_full = {row, col};
        idx_base = {row, col[ADDR_W-1:GRP_BITS], {GRP_BITS{1'b0}}};
    end

    // Write one word, or the whole group in test mode.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (tmode) begin
                for (int k = 0; k < GRP; k++) begin
                    mem[idx_base + IDX_W'(k)] <= wdata;
                end
            end else begin
                mem[idx_full] <= wdata;
            end
        end
    end

    // Normal read data and per-bit agreement of the group.
    always_comb begin
        rdata_norm = mem[idx_full];
        for (int b = 0; b < DATA_W; b++) begin
            for (int k = 0; k < GRP; k++) begin
                grp_bits[b][k] = mem[idx_base + IDX_W'(k)][b];
            end
            rdata_cmp[b] = (grp_bits[b] == '0) || (&grp_bits[b]);
        end
    end
endmodule

// File: rtl/dtm_out_stage.sv
// Output stage: registers read data, holds it while CAS is high inside
// the row cycle, and releases it when both strobes are high or on a write.
module dtm_out_stage #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              col_go,
    input  logic              we_n,
    input  logic              tmode,
    input  logic [DATA_W-1:0] rdata_norm,
    input  logic [DATA_W-1:0] rdata_cmp,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    // Capture, hold or release the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else if (col_go && we_n) begin
            dq_out <= tmode ? rdata_cmp : rdata_norm;
            dq_oe  <= 1'b1;
        end else if (col_go || (ras_n && cas_n)) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end
    end
endmodule

// File: rtl/dtm_compress_ram.sv
// Top: DRAM model with compressed parallel test mode. Ties the strobe
// decoder, cell array and output stage together. Assumes inputs are
// synchronous to clk and RAS is held high during reset.
module dtm_compress_ram #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 4,
    parameter int GRP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              test_mode
);
    logic [ADDR_W-1:0] row_q;
    logic              col_go;
    logic              wr_en;
    logic [DATA_W-1:0] rdata_norm;
    logic [DATA_W-1:0] rdata_cmp;

    // Write strobe for the array.
    always_comb wr_en = col_go & ~we_n;

    dtm_strobe_dec #(.ADDR_W(ADDR_W)) i_dec (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .row_q(row_q), .col_go(col_go), .test_mode(test_mode)
    );

    dtm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP_BITS(GRP_BITS)) i_arr (
        .clk(clk), .wr_en(wr_en), .tmode(test_mode), .row(row_q), .col(addr),
        .wdata(dq_in), .rdata_norm(rdata_norm), .rdata_cmp(rdata_cmp)
    );

    dtm_out_stage #(.DATA_W(DATA_W)) i_out (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .col_go(col_go),
        .we_n(we_n), .tmode(test_mode), .rdata_norm(rdata_norm),
        .rdata_cmp(rdata_cmp), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/dtm_checker.sv
// Checker: protocol properties of the test-mode model, observed at ports.
// Assumes ras_n high during reset.
module dtm_checker (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dq_oe,
    input logic test_mode
);
    logic rst_was_low;

    // Remember that the previous edge was under reset.
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    // Reset leaves mode and output cleared.
    always_ff @(posedge clk) begin
        if (rst_was_low) begin
            AST_RESET_CLEAR: assert (!test_mode && !dq_oe); // R1
        end
    end

    AST_WCBR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(ras_n) && !cas_n && !we_n |=> test_mode); // R2

    AST_CBR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(ras_n) && !cas_n && we_n |=> !test_mode); // R3

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$fell(ras_n) && !$rose(ras_n) |=> $stable(test_mode)); // R9

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n && cas_n |=> !dq_oe); // R8
endmodule

bind dtm_compress_ram dtm_checker i_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dq_oe(dq_oe), .test_mode(test_mode)
);

// File: tb/test_dtm_compress_ram.sv
module test_dtm_compress_ram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 4;
    localparam int NR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          test_mode;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] model [NR][NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    dtm_compress_ram #(.ADDR_W(AW), .DATA_W(DW), .GRP_BITS(2)) i_dtm_compress_ram (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .test_mode(test_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int r, input int c);
        return DW'((r * 7 + c * 3 + 1) % 16);
    endfunction

    function automatic logic [DW-1:0] cmp_exp(input int r, input int c);
        logic [DW-1:0] res;
        int base = c & ~3;
        for (int b = 0; b < DW; b++) begin
            int ones = 0;
            for (int k = 0; k < 4; k++) ones += model[r][base + k][b];
            res[b] = (ones == 0) || (ones == 4);
        end
        return res;
    endfunction

    task automatic do_write(input int r, input int c, input logic [DW-1:0] d, input bit tm);
        addr = AW'(r); ras_n = 0; @(negedge clk);
        addr = AW'(c); dq_in = d; we_n = 0; cas_n = 0; @(negedge clk);
        cas_n = 1; we_n = 1; @(negedge clk);
        ras_n = 1; @(negedge clk);
        if (tm) for (int k = 0; k < 4; k++) model[r][(c & ~3) + k] = d;
        else model[r][c] = d;
    endtask

    task automatic do_read(input int r, input int c, output logic [DW-1:0] q, output logic oe);
        addr = AW'(r); ras_n = 0; @(negedge clk);
        addr = AW'(c); we_n = 1; cas_n = 0; @(negedge clk);
        q = dq_out; oe = dq_oe;
        cas_n = 1; @(negedge clk);
        ras_n = 1; @(negedge clk);
    endtask

    task automatic cas_first(input logic w);
        cas_n = 0; we_n = w; @(negedge clk);
        ras_n = 0; @(negedge clk);
        @(negedge clk);
        ras_n = 1; cas_n = 1; we_n = 1; @(negedge clk);
    endtask

    task automatic ras_only(input int r);
        addr = AW'(r); ras_n = 0; @(negedge clk);
        @(negedge clk);
        ras_n = 1; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] q;
        logic oe;
        repeat (3) @(negedge clk);
        chk("R1 reset mode", test_mode, 0);
        chk("R1 reset oe", dq_oe, 0);
        rst_n = 1; @(negedge clk);
        chk("R1 after reset mode", test_mode, 0);

        // R5: exhaustive normal write and read back.
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NR; c++) do_write(r, c, pat(r, c), 1'b0);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NR; c++) begin
                do_read(r, c, q, oe);
                chk("R5 normal read data", q, pat(r, c));
                chk("R5 normal read oe", oe, 1);
            end

        // R3: CBR refresh outside test mode keeps mode off and array intact.
        cas_first(1'b1);
        chk("R3 cbr stays normal", test_mode, 0);
        do_read(3, 5, q, oe);
        chk("R3 cbr leaves array", q, model[3][5]);

        // R2: entry and repeated entry.
        cas_first(1'b0);
        chk("R2 wcbr enters", test_mode, 1);
        cas_first(1'b0);
        chk("R2 wcbr repeated keeps", test_mode, 1);

        // R7: compressed read sweep over the whole array.
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NR; c++) begin
                do_read(r, c, q, oe);
                chk("R7 compressed read", q, cmp_exp(r, c));
            end
        chk("R4 reads keep mode", test_mode, 1);

        // R6: test-mode writes with every low column value.
        for (int r = 0; r < NR; r += 5)
            for (int g = 0; g < NR / 4; g++) begin
                do_write(r, g * 4 + (g + r) % 4, DW'(g * 5 + r), 1'b1);
                chk("R9 write keeps mode", test_mode, 1);
                for (int k = 0; k < 4; k++) begin
                    do_read(r, g * 4 + k, q, oe);
                    chk("R7 agree after group write", q, 4'hF);
                end
            end

        // R4: RAS-only refresh exits.
        ras_only(2);
        chk("R4 ras-only exits", test_mode, 0);
        for (int r = 0; r < NR; r += 5)
            for (int c = 0; c < NR; c++) begin
                do_read(r, c, q, oe);
                chk("R6 group cells written", q, model[r][c]);
            end

        // R7: one differing cell, then compressed read.
        do_write(5, 6, 4'h3, 1'b0);
        do_write(5, 4, 4'hA, 1'b0);
        do_write(5, 5, 4'hA, 1'b0);
        do_write(5, 7, 4'hA, 1'b0);
        cas_first(1'b0);
        chk("R2 re-entry", test_mode, 1);
        for (int k = 0; k < 4; k++) begin
            do_read(5, 4 + k, q, oe);
            chk("R7 mismatch pins low", q, 4'h6);
        end
        cas_first(1'b1);
        chk("R3 cbr exits", test_mode, 0);

        // R8: extended data hold, write release, idle release.
        addr = 4'd1; ras_n = 0; @(negedge clk);
        addr = 4'd9; cas_n = 0; @(negedge clk);
        chk("R8 read oe", dq_oe, 1);
        cas_n = 1; @(negedge clk);
        chk("R8 hold oe with CAS high", dq_oe, 1);
        chk("R8 hold data", dq_out, model[1][9]);
        addr = 4'd2; dq_in = 4'hC; we_n = 0; cas_n = 0; @(negedge clk);
        chk("R8 write releases oe", dq_oe, 0);
        model[1][2] = 4'hC;
        cas_n = 1; we_n = 1; @(negedge clk);
        addr = 4'd2; cas_n = 0; @(negedge clk);
        chk("R5 page read after write", dq_out, 4'hC);
        cas_n = 1; ras_n = 1; @(negedge clk);
        chk("R8 idle releases oe", dq_oe, 0);

        // R1: reset during test mode.
        cas_first(1'b0);
        chk("R2 entry before reset", test_mode, 1);
        rst_n = 0; @(negedge clk);
        chk("R1 reset exits mode", test_mode, 0);
        rst_n = 1; @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule